// File: doc/BRIEF.md
# Byte ALU with Flag Generation

This block is the arithmetic and logic unit of an 8-bit accumulator machine. Each cycle it takes an operation code, the accumulator value, a second operand (from data memory or an immediate), and the current carry and auxiliary-carry flags. It returns the 8-bit result combinationally, in the same cycle.

It also produces new carry, auxiliary-carry, zero and overflow values. Each of these has its own write enable. The flags and enables are captured in registers on the rising clock edge, so the status storage outside the block sees them one cycle after the operation was presented. For subtraction, carry and auxiliary carry mean "no borrow". Instruction decode, the status register itself and skip sequencing are outside the block.

Top module: `byte_alu`

## Requirements
- R1: Opcodes 0 ADD, 1 ADC, 2 SUB and 3 SBC give these results mod 256:
  - ADD: acc + opnd.
  - ADC: acc + opnd + c_i.
  - SUB: acc - opnd.
  - SBC: acc - opnd - (1 - c_i).
- R2: For opcodes 0 to 3 the new carry has these meanings:
  - For addition it is the carry out of bit 7.
  - For subtraction it is 1 when no borrow occurs (acc >= opnd + borrow-in) and 0 when a borrow occurs.
- R3: For opcodes 0 to 3 the new auxiliary carry has these meanings:
  - For addition it is the carry out of bit 3.
  - For subtraction it is 1 when the low nibble needs no borrow from the high nibble.
- R4: Whenever zero is updated, it is 1 exactly when the result of that operation is 0x00.
- R5: For opcodes 0 to 3, overflow is 1 exactly when the signed two's-complement result does not fit in 8 bits (carry into bit 7 differs from carry out of bit 7).
- R6: Opcodes 5 AND, 6 OR, 7 XOR, 8 CPL (~acc), 13 INC (acc+1) and 14 DEC (acc-1) give the stated result and update only zero.
- R7: The rotate opcodes behave as follows:
  - 9 RL gives {acc[6:0],acc[7]} and 10 RR gives {acc[0],acc[7:1]}; neither updates any flag.
  - 11 RLC gives {acc[6:0],c_i} and 12 RRC gives {c_i,acc[7:1]}; both update only carry, which receives the bit shifted out.
- R8: Opcode 4 DAA adjusts the accumulator for decimal arithmetic and updates only carry:
  - It first adds 0x06 when acc[3:0] > 9 or ac_i = 1.
  - It then adds 0x60 when the upper nibble of that value exceeds 9, or c_i = 1, or the first step carried out.
  - The new carry is c_i OR either step's carry out.
- R9: The flag and enable outputs are registered one clock after the operation is presented. A flag output is 0 whenever its enable output is 0.
- R10: Opcode 15 is reserved: the result equals acc and no flag is updated.
- R11: An asynchronous active-low reset clears all flag and enable outputs while it is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Second operand (memory or immediate) |
| c_i | input | 1 | Current carry flag |
| ac_i | input | 1 | Current auxiliary-carry flag |
| res_o | output | 8 | Combinational result |
| c_o | output | 1 | Registered new carry |
| ac_o | output | 1 | Registered new auxiliary carry |
| z_o | output | 1 | Registered new zero |
| ov_o | output | 1 | Registered new overflow |
| c_we_o | output | 1 | Registered carry update enable |
| ac_we_o | output | 1 | Registered auxiliary-carry update enable |
| z_we_o | output | 1 | Registered zero update enable |
| ov_we_o | output | 1 | Registered overflow update enable |

## Verification
The block holds no state except the flag register stage. A wrong operand inversion or carry-in selection therefore appears at res_o in the same cycle as the offending opcode. A wrong flag or enable appears on the flag outputs exactly one edge later. The bench sweeps every opcode against every accumulator value, several operand patterns and all four carry/auxiliary-carry inputs. Each vector is checked against an integer model, so a fault in a single bit of a nibble carry or a signed range is exposed within the sweep of its opcode.

// File: rtl/byte_alu.sv
`timescale 1ns/1ps
module byte_alu (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] op_i,
  input  logic [7:0] acc_i,
  input  logic [7:0] opnd_i,
  input  logic       c_i,
  input  logic       ac_i,
  output logic [7:0] res_o,
  output logic       c_o,
  output logic       ac_o,
  output logic       z_o,
  output logic       ov_o,
  output logic       c_we_o,
  output logic       ac_we_o,
  output logic       z_we_o,
  output logic       ov_we_o
);
  localparam logic [3:0] OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBC = 4'd3;
  localparam logic [3:0] OP_DAA = 4'd4,  OP_AND = 4'd5,  OP_OR  = 4'd6,  OP_XOR = 4'd7;
  localparam logic [3:0] OP_CPL = 4'd8,  OP_RL  = 4'd9,  OP_RR  = 4'd10, OP_RLC = 4'd11;
  localparam logic [3:0] OP_RRC = 4'd12, OP_INC = 4'd13, OP_DEC = 4'd14;

  logic       is_sub, cin;
  logic [7:0] bb;
  logic [4:0] s_lo;
  logic [7:0] s_mid;
  logic [8:0] s_full;

  assign is_sub = (op_i == OP_SUB) || (op_i == OP_SBC);
  assign bb     = is_sub ? ~opnd_i : opnd_i;
  assign cin    = (op_i == OP_SUB) | (((op_i == OP_ADC) | (op_i == OP_SBC)) & c_i);
  assign s_lo   = {1'b0, acc_i[3:0]} + {1'b0, bb[3:0]} + {4'd0, cin};
  assign s_mid  = {1'b0, acc_i[6:0]} + {1'b0, bb[6:0]} + {7'd0, cin};
  assign s_full = {1'b0, acc_i} + {1'b0, bb} + {8'd0, cin};

  logic       lo_fix, hi_fix;
  logic [8:0] d_one, d_two;

  assign lo_fix = (acc_i[3:0] > 4'd9) | ac_i;
  assign d_one  = {1'b0, acc_i} + (lo_fix ? 9'h006 : 9'h000);
  assign hi_fix = (d_one[7:4] > 4'd9) | c_i | d_one[8];
  assign d_two  = {1'b0, d_one[7:0]} + (hi_fix ? 9'h060 : 9'h000);

  logic c_n, c_we, ac_we, z_we, ov_we;

  always_comb begin
    res_o = acc_i;
    c_n   = 1'b0;
    c_we  = 1'b0;
    ac_we = 1'b0;
    z_we  = 1'b0;
    ov_we = 1'b0;
    case (op_i)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
        res_o = s_full[7:0];
        c_n   = s_full[8];
        c_we  = 1'b1;
        ac_we = 1'b1;
        z_we  = 1'b1;
        ov_we = 1'b1;
      end
      OP_DAA: begin
        res_o = d_two[7:0];
        c_n   = c_i | d_one[8] | d_two[8];
        c_we  = 1'b1;
      end
      OP_AND: begin res_o = acc_i & opnd_i; z_we = 1'b1; end
      OP_OR:  begin res_o = acc_i | opnd_i; z_we = 1'b1; end
      OP_XOR: begin res_o = acc_i ^ opnd_i; z_we = 1'b1; end
      OP_CPL: begin res_o = ~acc_i;         z_we = 1'b1; end
      OP_INC: begin res_o = acc_i + 8'd1;   z_we = 1'b1; end
      OP_DEC: begin res_o = acc_i - 8'd1;   z_we = 1'b1; end
      OP_RL:  res_o = {acc_i[6:0], acc_i[7]};
      OP_RR:  res_o = {acc_i[0], acc_i[7:1]};
      OP_RLC: begin res_o = {acc_i[6:0], c_i}; c_n = acc_i[7]; c_we = 1'b1; end
      OP_RRC: begin res_o = {c_i, acc_i[7:1]}; c_n = acc_i[0]; c_we = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_o     <= 1'b0;
      ac_o    <= 1'b0;
      z_o     <= 1'b0;
      ov_o    <= 1'b0;
      c_we_o  <= 1'b0;
      ac_we_o <= 1'b0;
      z_we_o  <= 1'b0;
      ov_we_o <= 1'b0;
    end else begin
      c_o     <= c_we & c_n;
      ac_o    <= ac_we & s_lo[4];
      z_o     <= z_we & (res_o == 8'h00);
      ov_o    <= ov_we & (s_mid[7] ^ s_full[8]);
      c_we_o  <= c_we;
      ac_we_o <= ac_we;
      z_we_o  <= z_we;
      ov_we_o <= ov_we;
    end
  end
endmodule

// File: rtl/byte_alu_chk.sv
`timescale 1ns/1ps
module byte_alu_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] op_i,
  input logic [7:0] acc_i,
  input logic [7:0] opnd_i,
  input logic [7:0] res_o,
  input logic       c_o,
  input logic       ac_o,
  input logic       z_o,
  input logic       ov_o,
  input logic       c_we_o,
  input logic       ac_we_o,
  input logic       z_we_o,
  input logic       ov_we_o
);
  logic primed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;

  p_add_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(op_i) == 4'd0 |->
      {c_o, $past(res_o)} == ({1'b0, $past(acc_i)} + {1'b0, $past(opnd_i)}));

  p_add_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(op_i) == 4'd0 |->
      ov_o == (($past(acc_i[7]) == $past(opnd_i[7])) && ($past(res_o[7]) != $past(acc_i[7]))));

  p_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    primed && z_we_o |-> z_o == ($past(res_o) == 8'h00));

  p_rot_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    primed && ($past(op_i) == 4'd9 || $past(op_i) == 4'd10) |->
      !(c_we_o || ac_we_o || z_we_o || ov_we_o));

  p_rlc_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(op_i) == 4'd11 |-> c_we_o && c_o == $past(acc_i[7]));

  p_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (c_o |-> c_we_o) and (ac_o |-> ac_we_o) and (z_o |-> z_we_o) and (ov_o |-> ov_we_o));

  p_reserved_r10: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(op_i) == 4'd15 |-> $countones({c_we_o, ac_we_o, z_we_o, ov_we_o}) == 0);
endmodule

bind byte_alu byte_alu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_i(op_i), .acc_i(acc_i), .opnd_i(opnd_i),
  .res_o(res_o), .c_o(c_o), .ac_o(ac_o), .z_o(z_o), .ov_o(ov_o),
  .c_we_o(c_we_o), .ac_we_o(ac_we_o), .z_we_o(z_we_o), .ov_we_o(ov_we_o));

// File: tb/byte_alu_tb.sv
`timescale 1ns/1ps
module byte_alu_tb;
  localparam real CLK_NS = 5.0;
  localparam int  WD_CYCLES = 190000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] op;
  logic [7:0] a, b;
  logic       ci, aci;
  logic [7:0] res;
  logic       c_o, ac_o, z_o, ov_o, c_we, ac_we, z_we, ov_we;
  int compared = 0, mismatched = 0;

  always #(CLK_NS/2) clk = ~clk;

  byte_alu u_dut (
    .clk(clk), .rst_n(rst_n), .op_i(op), .acc_i(a), .opnd_i(b), .c_i(ci), .ac_i(aci),
    .res_o(res), .c_o(c_o), .ac_o(ac_o), .z_o(z_o), .ov_o(ov_o),
    .c_we_o(c_we), .ac_we_o(ac_we), .z_we_o(z_we), .ov_we_o(ov_we));

  task automatic chk(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s op=%0d a=%02h b=%02h c=%0b ac=%0b actual=%0h expected=%0h",
               req, what, op, a, b, ci, aci, act, exp);
    end
  endtask

  function automatic int sgn(input int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  task automatic model(input int o, input int x, input int y, input int c, input int h,
                       output int r, output int cn, output int an, output int ovn,
                       output int cw, output int aw, output int zw, output int ow);
    int t, bor, s;
    r = x; cn = 0; an = 0; ovn = 0; cw = 0; aw = 0; zw = 0; ow = 0;
    case (o)
      0, 1: begin
        t = (o == 1) ? c : 0;
        s = x + y + t;
        r = s % 256; cn = (s > 255);
        an = ((x % 16) + (y % 16) + t) > 15;
        s = sgn(x) + sgn(y) + t; ovn = (s > 127 || s < -128);
        cw = 1; aw = 1; zw = 1; ow = 1;
      end
      2, 3: begin
        bor = (o == 3) ? 1 - c : 0;
        s = x - y - bor;
        r = (s + 512) % 256; cn = (x >= y + bor);
        an = ((x % 16) >= (y % 16) + bor);
        s = sgn(x) - sgn(y) - bor; ovn = (s > 127 || s < -128);
        cw = 1; aw = 1; zw = 1; ow = 1;
      end
      4: begin
        t = x; cn = c;
        if ((x % 16) > 9 || h == 1) t = t + 6;
        if (t > 255) cn = 1;
        t = t % 256;
        if ((t / 16) > 9 || c == 1 || x + 6 > 255 && ((x % 16) > 9 || h == 1)) t = t + 96;
        if (t > 255) cn = 1;
        r = t % 256; cw = 1;
      end
      5:  begin r = x & y; zw = 1; end
      6:  begin r = x | y; zw = 1; end
      7:  begin r = x ^ y; zw = 1; end
      8:  begin r = 255 - x; zw = 1; end
      9:  r = ((x * 2) % 256) + x / 128;
      10: r = x / 2 + (x % 2) * 128;
      11: begin r = ((x * 2) % 256) + c; cn = x / 128; cw = 1; end
      12: begin r = x / 2 + c * 128; cn = x % 2; cw = 1; end
      13: begin r = (x + 1) % 256; zw = 1; end
      14: begin r = (x + 255) % 256; zw = 1; end
      default: ;
    endcase
  endtask

  function automatic string req_of_res(input int o);
    if (o <= 3) return "R1";
    if (o == 4) return "R8";
    if (o == 9 || o == 10 || o == 11 || o == 12) return "R7";
    if (o == 15) return "R10";
    return "R6";
  endfunction

  function automatic string req_of_c(input int o);
    if (o == 4) return "R8";
    if (o == 11 || o == 12) return "R7";
    return "R2";
  endfunction

  task automatic check_reset_state();
    chk("R11", "c",  c_o,  0); chk("R11", "ac", ac_o, 0);
    chk("R11", "z",  z_o,  0); chk("R11", "ov", ov_o, 0);
    chk("R11", "c_we", c_we, 0); chk("R11", "ac_we", ac_we, 0);
    chk("R11", "z_we", z_we, 0); chk("R11", "ov_we", ov_we, 0);
  endtask

  initial begin
    #(WD_CYCLES * CLK_NS);
    mismatched++; compared++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int r, cn, an, ovn, cw, aw, zw, ow, bv;
    rst_n = 1'b0; op = 4'd0; a = 8'hFF; b = 8'h01; ci = 1'b1; aci = 1'b1;
    repeat (3) @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    for (int o = 0; o < 16; o++) begin
      for (int x = 0; x < 256; x++) begin
        for (int bi = 0; bi < 8; bi++) begin
          case (bi)
            0: bv = 8'h00; 1: bv = 8'h01; 2: bv = 8'h0F; 3: bv = 8'h7F;
            4: bv = 8'h80; 5: bv = 8'hFF; 6: bv = 255 - x; default: bv = x;
          endcase
          for (int cc = 0; cc < 4; cc++) begin
            op = o[3:0]; a = x[7:0]; b = bv[7:0]; ci = cc[0]; aci = cc[1];
            model(o, x, bv, cc % 2, cc / 2, r, cn, an, ovn, cw, aw, zw, ow);
            #1;
            chk(req_of_res(o), "result", res, r);
            @(negedge clk);
            chk(req_of_c(o), "c",  c_o,  cw & cn);
            chk("R3", "ac", ac_o, aw & an);
            chk("R4", "z",  z_o,  zw & (r == 0));
            chk("R5", "ov", ov_o, ow & ovn);
            chk("R9", "c_we",  c_we,  cw); chk("R9", "ac_we", ac_we, aw);
            chk("R9", "z_we",  z_we,  zw); chk("R9", "ov_we", ov_we, ow);
          end
        end
      end
    end
    op = 4'd0; a = 8'hFF; b = 8'h01; ci = 1'b0; aci = 1'b0;
    @(negedge clk);
    chk("R2", "c before reset", c_o, 1);
    chk("R4", "z before reset", z_o, 1);
    rst_n = 1'b0;
    #1;
    check_reset_state();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule